// File: doc/BRIEF.md
# Serial Audio Transmit Shifter

This block turns parallel audio samples into a serial bit stream. A sample enters a one-word holding register. At each slot boundary it moves into a 32-bit shift register, and from there one bit leaves per bit-clock tick. Each slot is 32 ticks long. The sample's position inside the shift register depends on two things: an alignment control and the word-length class. A separate control chooses whether bit 31 or bit 0 leaves first. Every bit outside the active word goes out as zero.

Frames are made of a programmable number of slots. In internal mode the block generates a one-tick frame sync at the first bit of slot 0 and drives it onto the frame-sync pin. In external mode the block follows that pin as an input. A request pulse marks each sample taken from the holding register. A sticky underrun flag records a slot that started with no sample waiting.

A 32-bit configuration word holds the control bits. Only the asynchronous power-on reset clears it. The interface soft reset clears the datapath and leaves the configuration as it was.

Top module: `sats_top`

## Requirements
- R1: With the alignment bit (config bit 9) set, the sample sits in shift-register bits [L-1:0], where L is the active word length.
- R2: With the alignment bit clear and a word-length code of 3 to 7 (16, 18, 20, 22 or 24 bits), the sample's MSB sits at shift-register bit 31.
- R3: With the alignment bit clear and a word-length code of 0 to 2 (8, 10 or 12 bits), the sample's MSB sits at shift-register bit 15. Bits 31:16 are sent as zero.
- R4: Every slot sends 32 bits. With config bit 4 clear, bit 31 goes first and the bits follow in descending order. With config bit 4 set, bit 0 goes first and the bits follow in ascending order.
- R5: The config word uses these bits: 9 alignment, 8 and 7 FIFO enables, 6 frame-sync internal, 4 LSB-first, 1 request enable, 0 transmit enable. All other bits read as zero. After power-on reset the word reads 0x0000_0200.
- R6: Soft reset leaves the config word unchanged. It clears the holding register, the shifter and the underrun flag.
- R7: With config bit 6 set, fs_oe_o is high. fs_o pulses for one tick at the first bit of slot 0. A frame lasts (frame_words_i+1)*32 ticks.
- R8: With config bit 6 clear, fs_oe_o and fs_o stay low. A tick on which fs_pin_i is high starts a new slot, and the first bit of that slot appears on sd_o after that tick.
- R9: tx_req_o pulses for one cycle when a sample moves from the holding register into the shifter, but only when config bit 1 is set and config bits 8 and 7 are clear. Otherwise it stays low.
- R10: A slot that starts with an empty holding register sends 32 zero bits and sets urun_o. urun_o stays set until urun_clr_i is high for a cycle.
- R11: Sample bits at or above the active word length are not sent. Word-length codes 0 to 7 select 8, 10, 12, 16, 18, 20, 22 and 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Interface soft reset, synchronous |
| bclk_en_i | input | 1 | Bit-clock tick enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read value |
| wl_code_i | input | 3 | Word-length code |
| frame_words_i | input | FRAME_W | Slots per frame minus one |
| data_we_i | input | 1 | Sample write strobe into the holding register |
| data_i | input | 24 | Sample data, right-justified |
| urun_clr_i | input | 1 | Write-1 clear of the underrun flag |
| fs_pin_i | input | 1 | Frame-sync pin, input side |
| fs_o | output | 1 | Frame-sync pin, output side |
| fs_oe_o | output | 1 | Frame-sync pin output enable |
| sd_o | output | 1 | Serial data out |
| tx_req_o | output | 1 | Sample-consumed request pulse |
| urun_o | output | 1 | Sticky underrun flag |

## Verification
The hardest situation to reach from the ports is an externally timed slot that picks up a freshly written sample. The bench needs a slot start that it places itself, at a point where the free-running internal counter is not at a boundary. The stimulus writes the sample one tick ahead and raises fs_pin_i on the very next tick, so no counter-driven slot can consume the sample first. The bench then compares the 32 bits that follow with the expected placement.

// File: rtl/sats_pkg.sv
package sats_pkg;
  localparam int SR_W   = 32;
  localparam int DATA_W = 24;
  localparam int CNT_W  = $clog2(SR_W);

  typedef struct packed {
    logic align_lsb;
    logic fifo1_en;
    logic fifo0_en;
    logic fs_internal;
    logic lsb_first;
    logic irq_en;
    logic tx_en;
  } ctl_t;

  function automatic logic [5:0] wl_bits(input logic [2:0] code);
    logic [5:0] n;
    case (code)
      3'd0:    n = 6'd8;
      3'd1:    n = 6'd10;
      3'd2:    n = 6'd12;
      3'd3:    n = 6'd16;
      3'd4:    n = 6'd18;
      3'd5:    n = 6'd20;
      3'd6:    n = 6'd22;
      default: n = 6'd24;
    endcase
    return n;
  endfunction

  function automatic logic [SR_W-1:0] place_word(input logic [DATA_W-1:0] d,
                                                 input logic [2:0] code,
                                                 input logic align_lsb);
    logic [5:0]      n;
    logic [5:0]      ref_top;
    logic [SR_W-1:0] mask;
    logic [SR_W-1:0] w;
    n       = wl_bits(code);
    mask    = (32'd1 << n) - 32'd1;
    w       = {{(SR_W-DATA_W){1'b0}}, d} & mask;
    ref_top = (code < 3'd3) ? 6'd16 : 6'd32;
    if (!align_lsb) w = w << (ref_top - n);
    return w;
  endfunction
endpackage

// File: rtl/sats_ctl_reg.sv
module sats_ctl_reg
  import sats_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output ctl_t        ctl_o,
  output logic [31:0] rdata_o
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we_i) begin
      ctl_d.align_lsb   = wdata_i[9];
      ctl_d.fifo1_en    = wdata_i[8];
      ctl_d.fifo0_en    = wdata_i[7];
      ctl_d.fs_internal = wdata_i[6];
      ctl_d.lsb_first   = wdata_i[4];
      ctl_d.irq_en      = wdata_i[1];
      ctl_d.tx_en       = wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.align_lsb   <= 1'b1;
      ctl_q.fifo1_en    <= 1'b0;
      ctl_q.fifo0_en    <= 1'b0;
      ctl_q.fs_internal <= 1'b0;
      ctl_q.lsb_first   <= 1'b0;
      ctl_q.irq_en      <= 1'b0;
      ctl_q.tx_en       <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rdata_o    = '0;
    rdata_o[9] = ctl_q.align_lsb;
    rdata_o[8] = ctl_q.fifo1_en;
    rdata_o[7] = ctl_q.fifo0_en;
    rdata_o[6] = ctl_q.fs_internal;
    rdata_o[4] = ctl_q.lsb_first;
    rdata_o[1] = ctl_q.irq_en;
    rdata_o[0] = ctl_q.tx_en;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/sats_frame_tmr.sv
module sats_frame_tmr
  import sats_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic               fs_internal_i,
  input  logic               fs_pin_i,
  input  logic [FRAME_W-1:0] frame_words_i,
  output logic               load_o,
  output logic               fs_o
);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(SR_W-1);

  logic [CNT_W-1:0]   bit_q, bit_d;
  logic [FRAME_W-1:0] word_q, word_d;
  logic               fs_q, fs_d;
  logic               ext_start, frame0, tick_run;

  always_comb begin
    tick_run  = run_i && tick_i;
    ext_start = !fs_internal_i && fs_pin_i;
    frame0    = (bit_q == '0) && (word_q == '0);
    load_o    = tick_run && (ext_start || (bit_q == '0));

    bit_d  = bit_q;
    word_d = word_q;
    fs_d   = fs_q;
    if (!run_i) begin
      bit_d  = '0;
      word_d = '0;
      fs_d   = 1'b0;
    end else if (tick_i) begin
      fs_d = fs_internal_i && frame0;
      if (ext_start) begin
        bit_d  = CNT_W'(1);
        word_d = '0;
      end else begin
        bit_d = bit_q + CNT_W'(1);
        if (bit_q == BIT_LAST)
          word_d = (word_q >= frame_words_i) ? '0 : word_q + FRAME_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      word_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      word_q <= word_d;
      fs_q   <= fs_d;
    end
  end

  assign fs_o = fs_q;
endmodule

// File: rtl/sats_tx_shift.sv
module sats_tx_shift
  import sats_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst_i,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [2:0]        wl_code_i,
  input  logic              align_lsb_i,
  input  logic              lsb_first_i,
  input  logic              req_en_i,
  input  logic              urun_clr_i,
  output logic              sd_o,
  output logic              req_o,
  output logic              urun_o
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic [SR_W-1:0]   sh_q, sh_d, src;
  logic              sd_q, sd_d;
  logic              req_q, req_d;
  logic              urun_q, urun_d;
  logic              consume, starve;

  always_comb begin
    consume = load_i && full_q;
    starve  = load_i && !full_q;
    src     = full_q ? place_word(hold_q, wl_code_i, align_lsb_i) : '0;

    hold_d = data_we_i ? data_i : hold_q;
    full_d = data_we_i || (full_q && !consume);
    if (srst_i) full_d = 1'b0;

    sh_d = sh_q;
    sd_d = sd_q;
    if (srst_i || !run_i) begin
      sh_d = '0;
      sd_d = 1'b0;
    end else if (load_i) begin
      sd_d = lsb_first_i ? src[0] : src[SR_W-1];
      sh_d = lsb_first_i ? (src >> 1) : (src << 1);
    end else if (tick_i) begin
      sd_d = lsb_first_i ? sh_q[0] : sh_q[SR_W-1];
      sh_d = lsb_first_i ? (sh_q >> 1) : (sh_q << 1);
    end

    req_d = !srst_i && consume && req_en_i;

    urun_d = urun_q;
    if (srst_i)          urun_d = 1'b0;
    else if (starve)     urun_d = 1'b1;
    else if (urun_clr_i) urun_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
      sd_q   <= 1'b0;
      req_q  <= 1'b0;
      urun_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      sd_q   <= sd_d;
      req_q  <= req_d;
      urun_q <= urun_d;
    end
  end

  assign sd_o   = sd_q;
  assign req_o  = req_q;
  assign urun_o = urun_q;
endmodule

// File: rtl/sats_top.sv
module sats_top
  import sats_pkg::*;
#(
  parameter int FRAME_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst_i,
  input  logic               bclk_en_i,
  input  logic               cfg_we_i,
  input  logic [31:0]        cfg_wdata_i,
  output logic [31:0]        cfg_rdata_o,
  input  logic [2:0]         wl_code_i,
  input  logic [FRAME_W-1:0] frame_words_i,
  input  logic               data_we_i,
  input  logic [DATA_W-1:0]  data_i,
  input  logic               urun_clr_i,
  input  logic               fs_pin_i,
  output logic               fs_o,
  output logic               fs_oe_o,
  output logic               sd_o,
  output logic               tx_req_o,
  output logic               urun_o
);
  ctl_t ctl;
  logic run, load, fs_gen, req_en;

  sats_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .ctl_o   (ctl),
    .rdata_o (cfg_rdata_o)
  );

  assign run    = ctl.tx_en && !soft_rst_i;
  assign req_en = ctl.irq_en && !ctl.fifo0_en && !ctl.fifo1_en;

  sats_frame_tmr #(.FRAME_W(FRAME_W)) u_tmr (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .tick_i        (bclk_en_i),
    .fs_internal_i (ctl.fs_internal),
    .fs_pin_i      (fs_pin_i),
    .frame_words_i (frame_words_i),
    .load_o        (load),
    .fs_o          (fs_gen)
  );

  sats_tx_shift u_shf (
    .clk         (clk),
    .rst_n       (rst_n),
    .srst_i      (soft_rst_i),
    .run_i       (run),
    .tick_i      (bclk_en_i),
    .load_i      (load),
    .data_we_i   (data_we_i),
    .data_i      (data_i),
    .wl_code_i   (wl_code_i),
    .align_lsb_i (ctl.align_lsb),
    .lsb_first_i (ctl.lsb_first),
    .req_en_i    (req_en),
    .urun_clr_i  (urun_clr_i),
    .sd_o        (sd_o),
    .req_o       (tx_req_o),
    .urun_o      (urun_o)
  );

  assign fs_o    = fs_gen && ctl.fs_internal;
  assign fs_oe_o = ctl.fs_internal;
endmodule

// File: rtl/sats_checker.sv
module sats_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst_i,
  input logic        bclk_en_i,
  input logic        cfg_we_i,
  input logic [31:0] cfg_rdata_o,
  input logic        fs_o,
  input logic        fs_oe_o,
  input logic        tx_req_o,
  input logic        urun_o,
  input logic        urun_clr_i
);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata_o[31:10] == '0);

  a_r6_soft_keeps_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i && !cfg_we_i |=> $stable(cfg_rdata_o));

  a_r7_fs_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    fs_o && bclk_en_i |=> !fs_o);

  a_r8_no_drive_ext: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_oe_o |-> !fs_o);

  a_r9_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |=> !tx_req_o);

  a_r9_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o |-> $past(cfg_rdata_o[1] && !cfg_rdata_o[7] && !cfg_rdata_o[8]));

  a_r10_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    urun_o && !urun_clr_i && !soft_rst_i |=> urun_o);
endmodule

bind sats_top sats_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst_i  (soft_rst_i),
  .bclk_en_i   (bclk_en_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_rdata_o (cfg_rdata_o),
  .fs_o        (fs_o),
  .fs_oe_o     (fs_oe_o),
  .tx_req_o    (tx_req_o),
  .urun_o      (urun_o),
  .urun_clr_i  (urun_clr_i)
);

// File: tb/sats_top_bench.sv
module sats_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        bclk_en_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [2:0]  wl_code_i = '0;
  logic [3:0]  frame_words_i = '0;
  logic        data_we_i = 1'b0;
  logic [23:0] data_i = '0;
  logic        urun_clr_i = 1'b0;
  logic        fs_pin_i = 1'b0;
  logic        fs_o, fs_oe_o, sd_o, tx_req_o, urun_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sats_top u_sats_top (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wcfg(input logic [31:0] v);
    @(negedge clk); cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk); cfg_we_i = 1'b0;
  endtask

  task automatic wdata(input logic [23:0] v);
    @(negedge clk); data_we_i = 1'b1; data_i = v;
    @(negedge clk); data_we_i = 1'b0;
  endtask

  task automatic srst();
    @(negedge clk); soft_rst_i = 1'b1;
    @(negedge clk); soft_rst_i = 1'b0;
  endtask

  function automatic int wl_of(input logic [2:0] c);
    int t[8] = '{8, 10, 12, 16, 18, 20, 22, 24};
    return t[c];
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] d, input logic [2:0] c, input logic lsb_al);
    logic [31:0] w = '0;
    int n = wl_of(c);
    int base = lsb_al ? 0 : ((c < 3) ? 16 - n : 32 - n);
    for (int i = 0; i < n; i++) w[base + i] = d[i];
    return w;
  endfunction

  // Waits for an fs pulse, then captures 32 serial bits in send order.
  task automatic cap(output logic [31:0] seq, output int reqs);
    int guard = 0;
    reqs = 0;
    seq = '0;
    @(negedge clk);
    while (fs_o !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
    for (int k = 0; k < 32; k++) begin
      seq[k] = sd_o;
      if (tx_req_o) reqs++;
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] order(input logic [31:0] w, input logic lsb_first);
    logic [31:0] s;
    for (int k = 0; k < 32; k++) s[k] = lsb_first ? w[k] : w[31-k];
    return s;
  endfunction

  task automatic t_reset();
    check("R5 reset value", cfg_rdata_o, 32'h0000_0200);
    check("R10 urun at reset", {31'd0, urun_o}, 32'd0);
    check("R7 fs_oe at reset", {31'd0, fs_oe_o}, 32'd0);
  endtask

  task automatic t_cfg_rw();
    wcfg(32'hFFFF_FFFE);
    check("R5 writable mask", cfg_rdata_o, 32'h0000_03D2);
    wcfg(32'h0);
    check("R5 clear", cfg_rdata_o, 32'h0);
  endtask

  task automatic t_shape(input string req, input logic align_lsb, input logic lsb_first,
                         input logic [2:0] code, input logic [23:0] d, input logic irq,
                         input logic fifo0);
    logic [31:0] seq, cfg;
    int reqs;
    wcfg(32'h0);
    srst();
    wl_code_i = code;
    frame_words_i = 4'd0;
    wdata(d);
    cfg = 32'h41 | (32'(align_lsb) << 9) | (32'(lsb_first) << 4) | (32'(irq) << 1) | (32'(fifo0) << 7);
    wcfg(cfg);
    cap(seq, reqs);
    check(req, seq, order(exp_word(d, code, align_lsb), lsb_first));
    check("R9 request count", reqs, (irq && !fifo0) ? 1 : 0);
    wcfg(32'h0);
  endtask

  task automatic t_frame();
    int gap = 0;
    wcfg(32'h0);
    srst();
    frame_words_i = 4'd2;
    wcfg(32'h41);
    check("R7 fs_oe follows bit 6", {31'd0, fs_oe_o}, 32'd1);
    @(negedge clk);
    while (fs_o !== 1'b1 && gap < 300) begin @(negedge clk); gap++; end
    @(negedge clk);
    check("R7 fs width one tick", {31'd0, fs_o}, 32'd0);
    gap = 1;
    while (fs_o !== 1'b1 && gap < 400) begin @(negedge clk); gap++; end
    check("R7 frame period", gap, 96);
    wcfg(32'h0);
    frame_words_i = 4'd0;
  endtask

  task automatic t_ext();
    logic [31:0] seq, want;
    logic        fs_seen = 1'b0;
    wcfg(32'h0);
    srst();
    wl_code_i = 3'd3;
    wcfg(32'h0000_0001);
    repeat (7) @(negedge clk);
    data_we_i = 1'b1; data_i = 24'h00A5C3;
    @(negedge clk); data_we_i = 1'b0; fs_pin_i = 1'b1;
    @(negedge clk); fs_pin_i = 1'b0;
    for (int k = 0; k < 32; k++) begin
      seq[k] = sd_o;
      if (fs_o) fs_seen = 1'b1;
      @(negedge clk);
    end
    want = order(exp_word(24'h00A5C3, 3'd3, 1'b0), 1'b0);
    check("R8 external slot data", seq, want);
    check("R8 fs not driven", {30'd0, fs_seen, fs_oe_o}, 32'd0);
    wcfg(32'h0);
  endtask

  task automatic t_urun();
    logic any = 1'b0;
    wcfg(32'h0);
    srst();
    check("R6 urun cleared by soft reset", {31'd0, urun_o}, 32'd0);
    wcfg(32'h41);
    repeat (40) begin @(negedge clk); if (sd_o) any = 1'b1; end
    check("R10 underrun set", {31'd0, urun_o}, 32'd1);
    check("R10 zeros sent", {31'd0, any}, 32'd0);
    wcfg(32'h0);
    repeat (3) @(negedge clk);
    check("R10 sticky while idle", {31'd0, urun_o}, 32'd1);
    @(negedge clk); urun_clr_i = 1'b1;
    @(negedge clk); urun_clr_i = 1'b0;
    check("R10 write-1 clear", {31'd0, urun_o}, 32'd0);
  endtask

  task automatic t_soft();
    wcfg(32'h0000_03D2);
    srst();
    check("R6 config kept by soft reset", cfg_rdata_o, 32'h0000_03D2);
    wcfg(32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_shape("R1 LSB aligned 24b MSB-first", 1'b1, 1'b0, 3'd7, 24'hABCDEF, 1'b1, 1'b0);
    t_shape("R2 MSB aligned 20b MSB-first", 1'b0, 1'b0, 3'd5, 24'h9ABCD5, 1'b1, 1'b0);
    t_shape("R3 MSB aligned 12b ref bit15", 1'b0, 1'b0, 3'd2, 24'hFFFA5B, 1'b0, 1'b0);
    t_shape("R4 LSB-first MSB aligned 16b", 1'b0, 1'b1, 3'd3, 24'h12C3A5, 1'b1, 1'b1);
    t_shape("R11 8b word drops upper bits", 1'b1, 1'b1, 3'd0, 24'hFFFF96, 1'b1, 1'b0);
    t_shape("R3 MSB aligned 10b LSB-first", 1'b0, 1'b1, 3'd1, 24'h0003A7, 1'b0, 1'b0);
    t_frame();
    t_ext();
    t_urun();
    t_soft();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule